// File: doc/BRIEF.md
# Floating-Point Status and Trap Control Register

This block holds the floating-point status word of a processor's FPU. It keeps the rounding direction, a per-exception trap enable mask, a nonstandard (flush-to-zero) mode bit, a fixed implementation version, a 3-bit trap type code, and the current and accrued IEEE exception fields. Software can load the whole word in one write. After each floating-point operate instruction, the datapath presents a completion strobe. The strobe carries the five raised IEEE exception bits and flags for a sequence error, an unimplemented operation, an unfinished operation and a detected subnormal value.

On each completion the block either clears the trap type and folds the exceptions into the accrued field, or it picks one trap and records its code. A trap goes out as a one-cycle request on one of two outputs. One output is for IEEE exception traps and the other is for all remaining floating-point traps. The rounding direction and the flush-to-zero control are driven straight to the datapath.

Top module: `fpsr_ctrl`

## Requirements
- R1: After reset, every field of `status` reads 0 except the version field, which reads the `VERSION` parameter (default 5). `trap_ieee` and `trap_other` are low after reset.
- R2: The `status` layout is: current exceptions at bits [4:0], accrued exceptions at [9:5], trap enable mask at [14:10], nonstandard bit at [15], rounding direction at [17:16], trap type at [20:18] and version at [23:21]. A write with `sw_we` high loads bits [20:0] from `sw_wdata` in one cycle. The version bits never change.
- R3: `round_mode` always equals status[17:16], where 0 is nearest-even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity. `flush_zero` always equals status[15].
- R4: Suppose a completion raises no trap. Then the current field becomes `op_exc`, the accrued field becomes its old value OR `op_exc`, and the trap type becomes 0. Neither trap output pulses.
- R5: Suppose a completion has `op_exc & mask` nonzero and no higher-priority condition. Then the trap type becomes 1, the current field becomes `op_exc`, and the accrued field is unchanged. `trap_ieee` is high for exactly the cycle after the completion.
- R6: Sequence error, unimplemented and unfinished conditions set trap type 4, 3 and 2 respectively. `trap_other` is high for exactly the cycle after the completion. The current and accrued fields are left unchanged.
- R7: When several conditions occur together, the priority is sequence error, then unimplemented, then unfinished, then IEEE exception.
- R8: With the nonstandard bit at 0, an asserted `op_subnorm` is treated as an unfinished condition (trap type 2). With the bit at 1, `op_subnorm` has no effect.
- R9: A software write in the same cycle as a completion wins. The status then equals the written value, and no trap output pulses.
- R10: A completion never produces trap type 5, 6 or 7. `trap_ieee` and `trap_other` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 24 | Software write data (bits [23:21] ignored) |
| op_done | input | 1 | Operate instruction completion strobe |
| op_exc | input | 5 | IEEE exceptions raised by the completing instruction |
| op_unfin | input | 1 | Unfinished operation condition |
| op_unimpl | input | 1 | Unimplemented operation condition |
| op_seqerr | input | 1 | Sequence error condition |
| op_subnorm | input | 1 | Subnormal operand or result detected |
| status | output | 24 | Full status word |
| round_mode | output | 2 | Rounding direction to the datapath |
| flush_zero | output | 1 | Flush subnormals to zero |
| trap_ieee | output | 1 | IEEE exception trap request (one-cycle pulse) |
| trap_other | output | 1 | Other floating-point trap request (one-cycle pulse) |

## Verification
The hardest states to reach are the combinations where several trap conditions coincide with particular mask and mode settings. Only those combinations show the priority order, the subnormal interaction with the nonstandard bit, and the rule that trapped exceptions skip the accrued field. The stimulus first loads a chosen mask, mode and accrued pattern through the software write. It then sweeps every exception vector against every combination of the four condition flags. Separate cases drive a write and a completion in the same cycle, and try to overwrite the version field.

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl #(
  parameter logic [2:0] VERSION = 3'd5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_we,
  input  logic [23:0] sw_wdata,
  input  logic        op_done,
  input  logic [4:0]  op_exc,
  input  logic        op_unfin,
  input  logic        op_unimpl,
  input  logic        op_seqerr,
  input  logic        op_subnorm,
  output logic [23:0] status,
  output logic [1:0]  round_mode,
  output logic        flush_zero,
  output logic        trap_ieee,
  output logic        trap_other
);
  localparam logic [2:0] TT_NONE  = 3'd0;
  localparam logic [2:0] TT_IEEE  = 3'd1;
  localparam logic [2:0] TT_UNFIN = 3'd2;
  localparam logic [2:0] TT_UNIMP = 3'd3;
  localparam logic [2:0] TT_SEQ   = 3'd4;

  logic [4:0] cur, acc, tmask;
  logic       ns;
  logic [1:0] rnd;
  logic [2:0] tt;

  wire ieee_hit  = |(op_exc & tmask);
  wire unfin_hit = op_unfin | (op_subnorm & ~ns);

  logic [2:0] tt_nx;
  always_comb begin
    if (op_seqerr)      tt_nx = TT_SEQ;
    else if (op_unimpl) tt_nx = TT_UNIMP;
    else if (unfin_hit) tt_nx = TT_UNFIN;
    else if (ieee_hit)  tt_nx = TT_IEEE;
    else                tt_nx = TT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0; acc <= '0; tmask <= '0; ns <= 1'b0; rnd <= '0; tt <= TT_NONE;
      trap_ieee <= 1'b0; trap_other <= 1'b0;
    end else begin
      trap_ieee  <= 1'b0;
      trap_other <= 1'b0;
      if (sw_we) begin
        cur   <= sw_wdata[4:0];
        acc   <= sw_wdata[9:5];
        tmask <= sw_wdata[14:10];
        ns    <= sw_wdata[15];
        rnd   <= sw_wdata[17:16];
        tt    <= sw_wdata[20:18];
      end else if (op_done) begin
        tt <= tt_nx;
        case (tt_nx)
          TT_NONE: begin
            cur <= op_exc;
            acc <= acc | op_exc;
          end
          TT_IEEE: begin
            cur       <= op_exc;
            trap_ieee <= 1'b1;
          end
          default: trap_other <= 1'b1;
        endcase
      end
    end
  end

  assign status     = {VERSION, tt, rnd, ns, tmask, acc, cur};
  assign round_mode = rnd;
  assign flush_zero = ns;
endmodule

// File: rtl/fpsr_ctrl_chk.sv
module fpsr_ctrl_chk #(
  parameter logic [2:0] VERSION = 3'd5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_we,
  input logic [23:0] sw_wdata,
  input logic        op_done,
  input logic [23:0] status,
  input logic        trap_ieee,
  input logic        trap_other
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  assert_one_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_ieee && trap_other));

  assert_ieee_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ieee |-> status[20:18] == 3'd1);

  assert_other_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_other |-> (status[20:18] >= 3'd2 && status[20:18] <= 3'd4));

  assert_version_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[23:21] == VERSION);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    sw_we |=> (status[20:0] == $past(sw_wdata[20:0])) && !trap_ieee && !trap_other);

  assert_no_reserved_code_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (op_done && !sw_we) |=> status[20:18] <= 3'd4);
endmodule

bind fpsr_ctrl fpsr_ctrl_chk #(.VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata), .op_done(op_done),
  .status(status), .trap_ieee(trap_ieee), .trap_other(trap_other)
);

// File: tb/tb_fpsr_ctrl.sv
module tb_fpsr_ctrl;
  localparam logic [2:0] VER = 3'd5;

  logic clk = 0, rst_n = 0, sw_we = 0, op_done = 0;
  logic [23:0] sw_wdata = '0;
  logic [4:0] op_exc = '0;
  logic op_unfin = 0, op_unimpl = 0, op_seqerr = 0, op_subnorm = 0;
  logic [23:0] status;
  logic [1:0] round_mode;
  logic flush_zero, trap_ieee, trap_other;

  int n_cmp = 0, n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpsr_ctrl #(.VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata), .op_done(op_done),
    .op_exc(op_exc), .op_unfin(op_unfin), .op_unimpl(op_unimpl), .op_seqerr(op_seqerr),
    .op_subnorm(op_subnorm), .status(status), .round_mode(round_mode),
    .flush_zero(flush_zero), .trap_ieee(trap_ieee), .trap_other(trap_other)
  );

  logic [23:0] exp_st;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic sw_write(logic [23:0] d);
    @(negedge clk); sw_we = 1; sw_wdata = d;
    @(negedge clk); sw_we = 0;
    exp_st = {VER, d[20:0]};
    check("R2 write", status, exp_st);
    check("R3 round_mode", round_mode, exp_st[17:16]);
    check("R3 flush_zero", flush_zero, exp_st[15]);
  endtask

  task automatic op(logic [4:0] e, logic [3:0] fl, string tag);
    logic [4:0] cur, acc, msk; logic ns; logic [2:0] tt; logic ei, eo;
    cur = exp_st[4:0]; acc = exp_st[9:5]; msk = exp_st[14:10]; ns = exp_st[15];
    ei = 0; eo = 0;
    if (fl[0])                          begin tt = 3'd4; eo = 1; end
    else if (fl[1])                     begin tt = 3'd3; eo = 1; end
    else if (fl[2] || (fl[3] && !ns))   begin tt = 3'd2; eo = 1; end
    else if ((e & msk) != 0)            begin tt = 3'd1; ei = 1; cur = e; end
    else                                begin tt = 3'd0; cur = e; acc = acc | e; end
    @(negedge clk);
    op_done = 1; op_exc = e;
    op_seqerr = fl[0]; op_unimpl = fl[1]; op_unfin = fl[2]; op_subnorm = fl[3];
    @(negedge clk);
    op_done = 0; op_exc = '0; op_seqerr = 0; op_unimpl = 0; op_unfin = 0; op_subnorm = 0;
    exp_st = {VER, tt, exp_st[17:10], acc, cur};
    check(tag, status, exp_st);
    check({tag, " trap_ieee"}, trap_ieee, ei);
    check({tag, " trap_other"}, trap_other, eo);
    @(negedge clk);
    check({tag, " pulse_end"}, {trap_ieee, trap_other}, 2'b00);
  endtask

  function automatic string tag_of(logic [4:0] e, logic [3:0] fl, logic [4:0] m, logic ns);
    int n;
    n = int'(fl[0]) + int'(fl[1]) + int'(fl[2] || (fl[3] && !ns)) + int'((e & m) != 0);
    if (n > 1) return "R7 priority";
    if (fl[3] && !fl[0] && !fl[1] && !fl[2]) return "R8 subnormal";
    if (fl[0] || fl[1] || fl[2]) return "R6 other";
    if ((e & m) != 0) return "R5 ieee";
    return "R4 clean";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: actual %0d expected < 200000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] masks [4];
    masks[0] = 5'h00; masks[1] = 5'h1F; masks[2] = 5'h15; masks[3] = 5'h0A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    exp_st = {VER, 21'd0};
    check("R1 reset status", status, exp_st);
    check("R1 reset traps", {trap_ieee, trap_other}, 2'b00);

    sw_write(24'hFFFFFF);
    check("R2 version kept", status[23:21], VER);
    for (int r = 0; r < 4; r++) begin
      sw_write({3'b000, 3'd0, r[1:0], r[0], 5'h0A, 5'h11, 5'h03});
      check("R3 round each", round_mode, r[1:0]);
    end

    for (int mi = 0; mi < 4; mi++)
      for (int ns = 0; ns < 2; ns++)
        for (int fl = 0; fl < 16; fl++)
          for (int e = 0; e < 32; e++) begin
            if (e % 8 == 0)
              sw_write({3'b000, 3'd0, e[4:3], ns[0], masks[mi], 5'h04, 5'h00});
            op(e[4:0], fl[3:0], tag_of(e[4:0], fl[3:0], masks[mi], ns[0]));
          end

    // R4 accrual across several clean completions
    sw_write({3'b000, 3'd0, 2'd1, 1'b0, 5'h00, 5'h00, 5'h00});
    op(5'h01, 4'h0, "R4 accrue a");
    op(5'h08, 4'h0, "R4 accrue b");
    op(5'h00, 4'h0, "R4 accrue c");
    check("R4 accrued total", status[9:5], 5'h09);

    // R9 write coinciding with completion
    sw_write({3'b000, 3'd0, 2'd0, 1'b0, 5'h1F, 5'h00, 5'h00});
    @(negedge clk);
    sw_we = 1; sw_wdata = {3'b111, 3'd0, 2'd2, 1'b1, 5'h03, 5'h06, 5'h01};
    op_done = 1; op_exc = 5'h1F; op_seqerr = 1;
    @(negedge clk);
    sw_we = 0; op_done = 0; op_exc = '0; op_seqerr = 0;
    exp_st = {VER, 3'd0, 2'd2, 1'b1, 5'h03, 5'h06, 5'h01};
    check("R9 write wins", status, exp_st);
    check("R9 no trap", {trap_ieee, trap_other}, 2'b00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule